// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table index is the XOR of the fetch address's word bits with a global register that records recent branch outcomes, so branches whose behaviour depends on earlier branches land on separate counters.

The lookup port is purely combinational. The fetch stage presents an address and receives a taken / not-taken guess in the same cycle. The block also drives the current outcome history on the lookup port, and the pipeline carries that snapshot along with the branch. Once the branch has resolved, the update port receives three things: the branch address, the snapshot, and the real outcome. The block then trains the counter that the snapshot selects and shifts the outcome into the global history. Guesses never train the table.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 01, so every lookup address predicts not taken, and the outcome history reads all zeros.
- R2: A counter value of 10 or 11 predicts taken. A value of 00 or 01 predicts not taken.
- R3: The table index is address bits [IDX_W+1:2] XOR the history, with the history zero-extended to IDX_W bits. A lookup uses the live history. An update uses the snapshot supplied with it.
- R4: An update whose outcome is taken raises the indexed counter by one, and the counter stays at 11 once it reaches 11.
- R5: An update whose outcome is not taken lowers the indexed counter by one, and the counter stays at 00 once it reaches 00.
- R6: Each update shifts the history left by one and puts the actual outcome in bit 0. Without an update the history does not change.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the value the entry held before the update.
- R8: A counter at 11 that sees one not-taken outcome still predicts taken. A second not-taken outcome flips the prediction.
- R9: Address bits [1:0] and the bits above IDX_W+1 have no effect on the prediction.
- R10: Lookups alone never change any counter or the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| lk_hist | output | HIST_W | Current outcome history, to be carried with the branch |
| up_valid | input | 1 | A resolved branch is presented on the update port |
| up_pc | input | 32 | Address of the resolved branch |
| up_hist | input | HIST_W | History snapshot taken when the branch was predicted |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The embedded assertions check four things on every cycle. The history must shift in the real outcome on each update and hold steady otherwise. The history must be clear on leaving reset. A trained counter must move one step in the outcome's direction and stop at either end. What the assertions cannot show is that the right entry was reached: the XOR indexing, the use of the snapshot instead of the live history, the ignored address bits, the pre-update value seen on a same-cycle collision, and the one-anomaly hysteresis. These appear only in the bench's directed scenarios, which compare observed predictions against an independent model of the counters and the history.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WEAK_NT;

    // step the counter one state toward the observed outcome, saturating
    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_predict(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 6
) (
    input  logic [31:0]       pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int PC_LSB = 2;
    localparam int PC_MSB = PC_LSB + IDX_W - 1;

    logic [IDX_W-1:0] hist_ext;

    generate
        if (HIST_W == IDX_W) begin : g_same
            assign hist_ext = hist;
        end else begin : g_pad
            assign hist_ext = {{(IDX_W - HIST_W){1'b0}}, hist};
        end
    endgenerate

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[31:PC_MSB+1], pc[PC_LSB-1:0]};

    assign idx = pc[PC_MSB:PC_LSB] ^ hist_ext;

endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_q
);
    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= outcome;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
            end
        end
    endgenerate

    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(outcome));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));
    a_r1_hist_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> hist_q == '0);

endmodule

// File: rtl/gshare_table.sv
module gshare_table
    import gshare_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_RESET;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_train(tbl[wr_idx], wr_taken);
        end
    end

    // read is from the stored array, so a same-cycle write is not seen (R7)
    assign rd_taken = ctr_predict(tbl[rd_idx]);

    a_r4_inc: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] != CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == ctr_t'($past(tbl[wr_idx]) + 2'd1));
    a_r4_sat_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] == CTR_STRONG_T)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_T);
    a_r5_dec: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] != CTR_STRONG_NT)
        |=> tbl[$past(wr_idx)] == ctr_t'($past(tbl[wr_idx]) - 2'd1));
    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == CTR_STRONG_NT)
        |=> tbl[$past(wr_idx)] == CTR_STRONG_NT);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [31:0]       up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken
);
    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;

    gshare_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist_q   (ghist)
    );

    gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_index (
        .pc   (lk_pc),
        .hist (ghist),
        .idx  (lk_idx)
    );

    gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_index (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    gshare_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_taken (lk_taken),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    assign lk_hist = ghist;

endmodule

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 8;
    localparam int HIST_W = 6;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       lk_pc = '0;
    logic              lk_taken;
    logic [HIST_W-1:0] lk_hist;
    logic              up_valid = 1'b0;
    logic [31:0]       up_pc = '0;
    logic [HIST_W-1:0] up_hist = '0;
    logic              up_taken = 1'b0;

    int tests_run = 0;
    int tests_failed = 0;
    int model_ctr [DEPTH];
    logic [HIST_W-1:0] model_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_predictor #(.IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
    );

    task automatic check(input string req, input int actual, input int expected);
        tests_run++;
        if (actual != expected) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int idx_of(input logic [31:0] pc, input logic [HIST_W-1:0] h);
        return int'(pc[IDX_W+1:2] ^ {{(IDX_W-HIST_W){1'b0}}, h});
    endfunction

    // drive an update for one cycle and advance the model
    task automatic train(input int e, input logic [HIST_W-1:0] snap, input logic t);
        int i;
        @(negedge clk);
        up_valid = 1'b1;
        up_hist  = snap;
        up_pc    = 32'(((e ^ int'(snap)) & (DEPTH-1)) << 2);
        up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
        i = e;
        if (t) begin if (model_ctr[i] < 3) model_ctr[i]++; end
        else   begin if (model_ctr[i] > 0) model_ctr[i]--; end
        model_hist = {model_hist[HIST_W-2:0], t};
    endtask

    // look up the entry e under the live history
    task automatic probe(input string req, input int e);
        lk_pc = 32'(((e ^ int'(model_hist)) & (DEPTH-1)) << 2);
        #1;
        check(req, int'(lk_taken), int'(model_ctr[e] >= 2));
    endtask

    task automatic t_reset;
        check("R1 hist", int'(lk_hist), 0);
        for (int k = 0; k < 4; k++) begin
            lk_pc = 32'(k * 1236 + 4); #1;
            check("R1 pred", int'(lk_taken), 0);
        end
    endtask

    task automatic t_saturate_up;
        int e = 5;
        train(e, model_hist, 1'b1); probe("R4 01->10", e); probe("R2 10 taken", e);
        train(e, model_hist, 1'b1); probe("R4 10->11", e);
        train(e, model_hist, 1'b1); probe("R4 sat 11", e);
        train(e, model_hist, 1'b0); probe("R8 one anomaly", e);
        check("R8 still taken", int'(lk_taken), 1);
        train(e, model_hist, 1'b0); probe("R8 second flips", e);
        check("R8 now not taken", int'(lk_taken), 0);
    endtask

    task automatic t_saturate_down;
        int e = 9;
        train(e, model_hist, 1'b0); probe("R5 01->00", e);
        train(e, model_hist, 1'b0); probe("R5 sat 00", e);
        train(e, model_hist, 1'b1); probe("R5 00->01", e);
        check("R2 01 not taken", int'(lk_taken), 0);
        train(e, model_hist, 1'b1); probe("R5 up again", e);
        check("R5 after sat", int'(lk_taken), 1);
    endtask

    task automatic t_index_hash;
        logic [HIST_W-1:0] snap = 6'h05;
        // address word 3 with snapshot 5 must land on entry 6, not entry 3
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            up_valid = 1'b1; up_pc = 32'h0000_000C; up_hist = snap; up_taken = 1'b1;
            @(negedge clk);
            model_ctr[6] = (model_ctr[6] < 3) ? model_ctr[6] + 1 : 3;
            model_hist = {model_hist[HIST_W-2:0], 1'b1};
        end
        up_valid = 1'b0;
        probe("R3 hashed entry", 6);
        check("R3 entry 6 taken", int'(lk_taken), 1);
        probe("R3 unhashed entry", 3);
        check("R3 entry 3 untouched", int'(lk_taken), 0);
        check("R6 hist", int'(lk_hist), int'(model_hist));
    endtask

    task automatic t_ignored_bits;
        int base;
        base = ((6 ^ int'(model_hist)) & (DEPTH-1)) << 2;
        lk_pc = 32'(base) | 32'h3; #1;
        check("R9 low bits", int'(lk_taken), 1);
        lk_pc = 32'(base) | 32'hFFF0_0401; #1;
        check("R9 high bits", int'(lk_taken), 1);
    endtask

    task automatic t_history;
        logic [HIST_W-1:0] h0;
        h0 = model_hist;
        train(40, model_hist, 1'b1);
        check("R6 shift taken", int'(lk_hist), int'({h0[HIST_W-2:0], 1'b1}));
        train(41, model_hist, 1'b0);
        check("R6 shift not taken", int'(lk_hist), int'({h0[HIST_W-3:0], 2'b10}));
        train(42, model_hist, 1'b1);
        check("R6 model", int'(lk_hist), int'(model_hist));
    endtask

    task automatic t_lookups_only;
        logic [HIST_W-1:0] h0;
        h0 = model_hist;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lk_pc = 32'(k * 4);
        end
        @(negedge clk);
        check("R10 hist", int'(lk_hist), int'(h0));
        probe("R10 entry 6", 6);
        probe("R10 entry 9", 9);
    endtask

    task automatic t_collision;
        int e = 20;
        train(e, model_hist, 1'b1); // weakly taken
        @(negedge clk);
        lk_pc = 32'(((e ^ int'(model_hist)) & (DEPTH-1)) << 2);
        up_valid = 1'b1; up_hist = model_hist; up_pc = lk_pc; up_taken = 1'b0;
        #1;
        check("R7 pre-update value", int'(lk_taken), 1);
        @(negedge clk);
        up_valid = 1'b0;
        model_ctr[e] = model_ctr[e] - 1;
        model_hist = {model_hist[HIST_W-2:0], 1'b0};
        probe("R7 after write", e);
        check("R7 now not taken", int'(lk_taken), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model_ctr[i] = 1;
        model_hist = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_saturate_up();
        t_saturate_down();
        t_index_hash();
        t_ignored_bits();
        t_history();
        t_lookups_only();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule